// File: doc/BRIEF.md
# Two-Port Source Select and Drive Control

This block connects two 18-bit bidirectional ports, A and B, to a pair of FIFOs that move data in opposite directions. Each port has a source select and an output enable. The source select picks one of two words to drive. One is the live word arriving on the other port. The other is the head word of the FIFO that feeds this port. The output enable decides whether the port drives that word or stays high-impedance and acts as an input. The pads are modelled as three separate vectors per port: input, output and output enable. The FIFOs and the pad drivers are outside the block.

Every source change goes through a break-before-make sequence. The output word is registered, so a change of select makes the port hold its last whole word for one cycle before the new source takes over. The port therefore never shows a word with some bits from the old source and some from the new one. Each port runs the same four-state machine:
- `PS_LIVE` moves to `PS_TO_STORED` when the select is high.
- `PS_TO_STORED` moves to `PS_STORED` unconditionally.
- `PS_STORED` moves to `PS_TO_LIVE` when the select is low.
- `PS_TO_LIVE` moves to `PS_LIVE` unconditionally.

The output register loads the live word in `PS_LIVE`, loads the FIFO word in `PS_STORED`, and holds its value in both transfer states. The output enables are also registered, one cycle behind their inputs. The reset is synchronous and active low.

Top module: `xbus_sel`

## Requirements
- R1: While `rst_n` is low, at each clock edge both output-enable vectors go to all zeros, both output words go to zero, and both port machines go to `PS_LIVE`.
- R2: One clock after `b_en` is sampled high, every bit of `b_oe` is 1. One clock after `b_en` is sampled low, every bit is 0.
- R3: `a_oe` follows `a_en` in the same way as R2 describes for port B.
- R4: While port B is settled in `PS_LIVE` (`b_sel` low), `b_out` equals the value `a_in` had at the previous clock edge.
- R5: While port B is settled in `PS_STORED` (`b_sel` high), `b_out` equals the value `fifo_ab_word` had at the previous clock edge.
- R6: While port A is settled in `PS_LIVE` (`a_sel` low), `a_out` equals the value `b_in` had at the previous clock edge.
- R7: While port A is settled in `PS_STORED` (`a_sel` high), `a_out` equals the value `fifo_ba_word` had at the previous clock edge.
- R8: Take the first edge at which a changed select is sampled. At that edge the port still loads its old source. At the next edge the port holds that word. From the edge after that, it loads the new source.
- R9: Whenever a port's output word changes, the new value equals the whole previous-edge value of one of that port's two sources.
- R10: The two selects and the two enables act independently in all sixteen combinations. A port's output word keeps following its source while that port's enable is low.
- R11: A transfer state always runs to completion. If the select returns to its old level during the transfer state, the port first settles on the new source and then makes a full transfer back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_sel | input | 1 | Port A source: 0 = live word from port B, 1 = B-to-A FIFO head |
| b_sel | input | 1 | Port B source: 0 = live word from port A, 1 = A-to-B FIFO head |
| a_en | input | 1 | Port A drive request |
| b_en | input | 1 | Port B drive request |
| fifo_ab_word | input | 18 | Head word of the A-to-B FIFO |
| fifo_ba_word | input | 18 | Head word of the B-to-A FIFO |
| a_in | input | 18 | Pad input of port A |
| a_out | output | 18 | Pad output word of port A |
| a_oe | output | 18 | Pad output enables of port A |
| b_in | input | 18 | Pad input of port B |
| b_out | output | 18 | Pad output word of port B |
| b_oe | output | 18 | Pad output enables of port B |

## Verification
The bench sweeps all sixteen settings of the two selects and two enables. In every setting it gives the two live inputs and the two FIFO words distinct values. A port that takes its word from the wrong source, or from the other port's FIFO, therefore gives a visibly wrong value, and so does an enable tied to the wrong port.

The switch tests change the live and FIFO inputs on every cycle around a select change. This separates loading the old source, holding during the transfer state, and loading the new source, one cycle from the next. A further pattern reverts the select in the middle of a transfer, which shows that the transfer state always runs to its end.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [1:0] {
        PS_LIVE      = 2'd0,
        PS_TO_STORED = 2'd1,
        PS_STORED    = 2'd2,
        PS_TO_LIVE   = 2'd3
    } path_state_t;
endpackage

// File: rtl/xport_path.sv
module xport_path
    import xbus_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         use_stored,
    input  logic [W-1:0] live_word,
    input  logic [W-1:0] stored_word,
    output logic [W-1:0] drive_word
);
    path_state_t state_q, state_d;
    logic [W-1:0] drv_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_LIVE;
        else        state_q <= state_d;
    end

    // transitions: each transfer state lasts exactly one cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_LIVE:      if (use_stored)  state_d = PS_TO_STORED;
            PS_TO_STORED:                  state_d = PS_STORED;
            PS_STORED:    if (!use_stored) state_d = PS_TO_LIVE;
            PS_TO_LIVE:                    state_d = PS_LIVE;
            default:                       state_d = PS_LIVE;
        endcase
    end

    // output register: whole-word load from one source, hold in transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else begin
            unique case (state_q)
                PS_LIVE:   drv_q <= live_word;
                PS_STORED: drv_q <= stored_word;
                default:   drv_q <= drv_q;
            endcase
        end
    end

    assign drive_word = drv_q;
endmodule

// File: rtl/xport_oe.sv
module xport_oe #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] oe
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en;
    end

    for (genvar i = 0; i < W; i++) begin : g_pad
        assign oe[i] = en_q;
    end
endmodule

// File: rtl/xbus_sel.sv
module xbus_sel #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         a_sel,
    input  logic         b_sel,
    input  logic         a_en,
    input  logic         b_en,
    input  logic [W-1:0] fifo_ab_word,
    input  logic [W-1:0] fifo_ba_word,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);
    // port A sources: live word from B, or B-to-A FIFO head
    xport_path #(.W(W)) u_path_a (
        .clk        (clk),
        .rst_n      (rst_n),
        .use_stored (a_sel),
        .live_word  (b_in),
        .stored_word(fifo_ba_word),
        .drive_word (a_out)
    );

    // port B sources: live word from A, or A-to-B FIFO head
    xport_path #(.W(W)) u_path_b (
        .clk        (clk),
        .rst_n      (rst_n),
        .use_stored (b_sel),
        .live_word  (a_in),
        .stored_word(fifo_ab_word),
        .drive_word (b_out)
    );

    xport_oe #(.W(W)) u_oe_a (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (a_en),
        .oe   (a_oe)
    );

    xport_oe #(.W(W)) u_oe_b (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (b_en),
        .oe   (b_oe)
    );
endmodule

// File: rtl/xbus_sel_chk.sv
module xbus_sel_chk
    import xbus_pkg::*;
#(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic         a_en,
    input logic         b_en,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] fifo_ab_word,
    input logic [W-1:0] fifo_ba_word,
    input logic [W-1:0] a_out,
    input logic [W-1:0] b_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_oe,
    input path_state_t  st_a,
    input path_state_t  st_b
);
    // R2
    b_oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (b_oe == {W{$past(b_en)}}));

    // R3
    a_oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (a_oe == {W{$past(a_en)}}));

    // R9
    b_whole_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(b_out)) |->
            (b_out == $past(a_in) || b_out == $past(fifo_ab_word)));

    // R9
    a_whole_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(a_out)) |->
            (a_out == $past(b_in) || a_out == $past(fifo_ba_word)));

    // R8
    b_gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_b == PS_TO_STORED || st_b == PS_TO_LIVE) |=> $stable(b_out));

    // R8
    a_gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_a == PS_TO_STORED || st_a == PS_TO_LIVE) |=> $stable(a_out));

    // R11
    b_gap_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_b == PS_TO_STORED) |=> (st_b == PS_STORED));

    // R11
    a_gap_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_a == PS_TO_LIVE) |=> (st_a == PS_LIVE));
endmodule

bind xbus_sel xbus_sel_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .a_en        (a_en),
    .b_en        (b_en),
    .a_in        (a_in),
    .b_in        (b_in),
    .fifo_ab_word(fifo_ab_word),
    .fifo_ba_word(fifo_ba_word),
    .a_out       (a_out),
    .b_out       (b_out),
    .a_oe        (a_oe),
    .b_oe        (b_oe),
    .st_a        (u_path_a.state_q),
    .st_b        (u_path_b.state_q)
);

// File: tb/xbus_sel_bench.sv
module xbus_sel_bench;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         a_sel = 1'b0, b_sel = 1'b0, a_en = 1'b0, b_en = 1'b0;
    logic [W-1:0] fifo_ab_word = '0, fifo_ba_word = '0, a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    xbus_sel #(.W(W)) u_xbus_sel (
        .clk(clk), .rst_n(rst_n),
        .a_sel(a_sel), .b_sel(b_sel), .a_en(a_en), .b_en(b_en),
        .fifo_ab_word(fifo_ab_word), .fifo_ba_word(fifo_ba_word),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one clock edge, then back to the falling edge for sampling/driving
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_words(input logic [W-1:0] ai, input logic [W-1:0] bi,
                             input logic [W-1:0] fab, input logic [W-1:0] fba);
        a_in = ai; b_in = bi; fifo_ab_word = fab; fifo_ba_word = fba;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        a_sel = 1'b1; b_sel = 1'b1; a_en = 1'b1; b_en = 1'b1;
        set_words(18'h11111, 18'h22222, 18'h33333, 18'h04444);
        repeat (3) step();
        check("R1", "a_oe in reset", a_oe, '0);
        check("R1", "b_oe in reset", b_oe, '0);
        check("R1", "a_out in reset", a_out, '0);
        check("R1", "b_out in reset", b_out, '0);
        a_sel = 1'b0; b_sel = 1'b0; a_en = 1'b0; b_en = 1'b0;
        rst_n = 1'b1;
        step();
        // machines start live: outputs follow the live words right away
        check("R1", "b_out live after reset", b_out, 18'h11111);
        check("R1", "a_out live after reset", a_out, 18'h22222);
    endtask

    // R10: all sixteen select/enable settings
    task automatic t_sweep();
        for (int c = 0; c < 16; c++) begin
            logic [W-1:0] ai, bi, fab, fba;
            a_sel = c[0]; b_sel = c[1]; a_en = c[2]; b_en = c[3];
            repeat (4) step();
            ai  = 18'h0A000 + W'(c);
            bi  = 18'h0B000 + W'(c);
            fab = 18'h1C000 + W'(c);
            fba = 18'h1D000 + W'(c);
            set_words(ai, bi, fab, fba);
            step();
            check(c[1] ? "R5" : "R4", "R10 b_out", b_out, c[1] ? fab : ai);
            check(c[0] ? "R7" : "R6", "R10 a_out", a_out, c[0] ? fba : bi);
            check("R2", "R10 b_oe", b_oe, {W{c[3]}});
            check("R3", "R10 a_oe", a_oe, {W{c[2]}});
        end
    endtask

    // R8: break-before-make on port B in both directions
    task automatic t_switch_b();
        b_sel = 1'b0;
        repeat (4) step();
        b_sel = 1'b1; set_words(18'h00101, 18'h0, 18'h00201, 18'h0);
        step();
        check("R8", "b still old source", b_out, 18'h00101);
        set_words(18'h00102, 18'h0, 18'h00202, 18'h0);
        step();
        check("R8", "b hold in transfer", b_out, 18'h00101);
        set_words(18'h00103, 18'h0, 18'h00203, 18'h0);
        step();
        check("R8", "b new source fifo", b_out, 18'h00203);
        b_sel = 1'b0; set_words(18'h00104, 18'h0, 18'h00204, 18'h0);
        step();
        check("R8", "b still fifo", b_out, 18'h00204);
        set_words(18'h00105, 18'h0, 18'h00205, 18'h0);
        step();
        check("R8", "b hold back", b_out, 18'h00204);
        set_words(18'h00106, 18'h0, 18'h00206, 18'h0);
        step();
        check("R8", "b new source live", b_out, 18'h00106);
    endtask

    // R8 on port A
    task automatic t_switch_a();
        a_sel = 1'b0;
        repeat (4) step();
        a_sel = 1'b1; set_words(18'h0, 18'h00301, 18'h0, 18'h00401);
        step();
        check("R8", "a still old source", a_out, 18'h00301);
        set_words(18'h0, 18'h00302, 18'h0, 18'h00402);
        step();
        check("R8", "a hold in transfer", a_out, 18'h00301);
        set_words(18'h0, 18'h00303, 18'h0, 18'h00403);
        step();
        check("R8", "a new source fifo", a_out, 18'h00403);
        a_sel = 1'b0;
        repeat (4) step();
    endtask

    // R11: select reverts during the transfer state
    task automatic t_revert_b();
        b_sel = 1'b0;
        repeat (4) step();
        b_sel = 1'b1; set_words(18'h00501, 18'h0, 18'h00601, 18'h0);
        step();
        b_sel = 1'b0; set_words(18'h00502, 18'h0, 18'h00602, 18'h0);
        step();
        check("R11", "b hold while reverting", b_out, 18'h00501);
        set_words(18'h00503, 18'h0, 18'h00603, 18'h0);
        step();
        check("R11", "b settles on fifo", b_out, 18'h00603);
        set_words(18'h00504, 18'h0, 18'h00604, 18'h0);
        step();
        check("R11", "b hold on way back", b_out, 18'h00603);
        set_words(18'h00505, 18'h0, 18'h00605, 18'h0);
        step();
        check("R11", "b live again", b_out, 18'h00505);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_sweep();
        t_switch_b();
        t_switch_a();
        t_revert_b();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule